// File: doc/BRIEF.md
# Multi-Channel Input Deglitch Filter

This block conditions a word of asynchronous digital input lines, 24 by default, so that brief pulses never reach the logic that samples them. Each line first passes through a two-flop synchronizer. Where the channel's enable bit is set, a small per-channel state machine then holds the last accepted level. It accepts a new level only once the synchronized line has kept that level for a programmed number of slow ticks. One prescaler drives all channels and pulses once every `TICK_DIV` clocks, which gives 200 ns per tick at 50 MHz. Channels with the enable bit clear pass the synchronized line straight to the output.

Software sets up the block through a byte-wide write port. The stability interval is shared by all channels. It is written into a staging register one byte at a time and has no effect until a command write commits it. The enable mask is written the same way and takes effect at once. A second command bit resynchronizes every filter to its present input. The filtered word is read back as bytes through a combinational read port.

Each channel state machine has two states. In `CH_IDLE` the held level matches the input. In `CH_COUNT` the input differs from the held level and stability ticks are being counted. The transitions are:
- **IDLE→COUNT**: the input differs from the held level and the interval is non-zero.
- **IDLE→IDLE with update**: the input differs and the interval is zero.
- **COUNT→IDLE on reversal**: the input returns to the held level. The count is discarded.
- **COUNT→IDLE on expiry**: the count has reached the interval. The new level is accepted.
- **any→IDLE**: on reset, on a clear-filter command, or while the channel is disabled. The held level is loaded from the input.

Top module: `din_deglitch`

## Requirements
- R1: After reset every enable bit is 0, the committed interval is 0 and each output equals its synchronized input.
- R2: A channel whose enable bit is 0 drives its output with the input delayed by exactly two clock edges (the synchronizer) and nothing more.
- R3: The shared tick pulses for one clock in every `TICK_DIV` clocks and never in two consecutive clocks; filter timing is measured only in these ticks.
- R4: For an enabled channel, a clock edge counts as a tick edge when the tick is high at that edge. When the synchronized input differs from the held level, the count starts from zero and rises by one at each tick edge. The output takes the new level at the first edge at which the count already equals the committed interval, and only then.
- R5: If the synchronized input returns to the held level before acceptance, the count is discarded and the output does not change.
- R6: The interval is staged by writes to address 4 (bits 7:0), address 5 (bits 15:8) and address 6 (low 4 bits only, giving bits 19:16; the upper nibble is dropped). The interval in force changes only when a write to address 12 has bit 0 set, which copies the staged value.
- R7: A write to address 12 with bit 1 set loads every held level from its synchronized input and discards every count, at that clock edge.
- R8: Writes to addresses 8, 9 and 10 set enable bits for channels 0–7, 8–15 and 16–23; bit k of the byte at address 8+b enables channel 8b+k from the next edge.
- R9: The read port returns filtered channels 0–7 at address 0, 8–15 at address 1 and 16–23 at address 2, with channel 0 in bit 0. Every other address reads 0, and writes to addresses 0–2 change nothing.
- R10: With a committed interval of 0, an enabled channel follows its synchronized input one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| din | input | NCH | Asynchronous raw input lines |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data byte |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Read data byte (combinational) |
| filt_out | output | NCH | Filtered input word |

## Verification
The filter is tried with four kinds of input pattern. Random words that change every clock while all channels are disabled, or enabled with a zero interval, separate the two-flop pass-through from the one-flop-later path. Long steady steps with a committed interval of three ticks show that acceptance lands on the exact tick edge. Pulses shorter than the interval must leave no trace, while pulses with random lengths around one tick expose off-by-one errors in counting and in prescaler phase. Writes around the staging and command addresses, including a stale staged value, an upper-nibble write and a clear issued mid-count, show that configuration takes effect only at the documented moment.

// File: rtl/dgl_pkg.sv
package dgl_pkg;

    localparam int DGL_BYTE_W     = 8;
    localparam int DGL_RD_BASE    = 0;
    localparam int DGL_IVL_BASE   = 4;
    localparam int DGL_EN_BASE    = 8;
    localparam int DGL_CMD_ADDR   = 12;
    localparam int DGL_CMD_COMMIT = 0;
    localparam int DGL_CMD_CLEAR  = 1;

    typedef enum logic {
        CH_IDLE  = 1'b0,
        CH_COUNT = 1'b1
    } ch_state_t;

endpackage

// File: rtl/dgl_tick_gen.sv
module dgl_tick_gen #(
    parameter int DIV = 10
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt;

    assign tick = (cnt == CW'(DIV - 1));

    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/dgl_sync.sv
module dgl_sync #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        meta <= d;
        q    <= meta;
    end
endmodule

// File: rtl/dgl_regs.sv
module dgl_regs
    import dgl_pkg::*;
#(
    parameter int NCH    = 24,
    parameter int IVL_W  = 20,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output logic [NCH-1:0]    en_mask,
    output logic [IVL_W-1:0]  ivl_active,
    output logic [IVL_W-1:0]  ivl_staged,
    output logic              clr_filt
);
    localparam int NB = (NCH + DGL_BYTE_W - 1) / DGL_BYTE_W;
    localparam int IB = (IVL_W + DGL_BYTE_W - 1) / DGL_BYTE_W;

    logic cmd_hit;
    logic commit;

    assign cmd_hit  = wr_en && (wr_addr == ADDR_W'(DGL_CMD_ADDR));
    assign commit   = cmd_hit && wr_data[DGL_CMD_COMMIT];
    assign clr_filt = cmd_hit && wr_data[DGL_CMD_CLEAR];

    for (genvar b = 0; b < NB; b++) begin : g_en_lane
        localparam int LW = ((NCH - b*DGL_BYTE_W) < DGL_BYTE_W) ? (NCH - b*DGL_BYTE_W) : DGL_BYTE_W;
        always_ff @(posedge clk) begin
            if (!rst_n)
                en_mask[b*DGL_BYTE_W +: LW] <= '0;
            else if (wr_en && wr_addr == ADDR_W'(DGL_EN_BASE + b))
                en_mask[b*DGL_BYTE_W +: LW] <= wr_data[LW-1:0];
        end
    end

    for (genvar b = 0; b < IB; b++) begin : g_ivl_lane
        localparam int LW = ((IVL_W - b*DGL_BYTE_W) < DGL_BYTE_W) ? (IVL_W - b*DGL_BYTE_W) : DGL_BYTE_W;
        always_ff @(posedge clk) begin
            if (!rst_n)
                ivl_staged[b*DGL_BYTE_W +: LW] <= '0;
            else if (wr_en && wr_addr == ADDR_W'(DGL_IVL_BASE + b))
                ivl_staged[b*DGL_BYTE_W +: LW] <= wr_data[LW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      ivl_active <= '0;
        else if (commit) ivl_active <= ivl_staged;
    end
endmodule

// File: rtl/dgl_chan.sv
module dgl_chan
    import dgl_pkg::*;
#(
    parameter int IVL_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             clr,
    input  logic             en,
    input  logic             sync_in,
    input  logic [IVL_W-1:0] ivl,
    output logic             filt_o
);
    ch_state_t        st, st_n;
    logic             held, held_n;
    logic [IVL_W-1:0] cnt, cnt_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= CH_IDLE;
            held <= sync_in;
            cnt  <= '0;
        end else begin
            st   <= st_n;
            held <= held_n;
            cnt  <= cnt_n;
        end
    end

    always_comb begin
        st_n   = st;
        held_n = held;
        cnt_n  = cnt;
        if (!en || clr) begin
            st_n   = CH_IDLE;
            held_n = sync_in;
            cnt_n  = '0;
        end else begin
            unique case (st)
                CH_IDLE: begin
                    if (sync_in != held) begin
                        if (ivl == '0) begin
                            held_n = sync_in;
                        end else begin
                            st_n  = CH_COUNT;
                            cnt_n = tick ? IVL_W'(1) : '0;
                        end
                    end
                end
                CH_COUNT: begin
                    if (sync_in == held) begin
                        st_n  = CH_IDLE;
                        cnt_n = '0;
                    end else if (cnt >= ivl) begin
                        st_n   = CH_IDLE;
                        held_n = sync_in;
                        cnt_n  = '0;
                    end else if (tick) begin
                        cnt_n = cnt + 1'b1;
                    end
                end
                default: st_n = CH_IDLE;
            endcase
        end
    end

    always_comb begin
        filt_o = en ? held : sync_in;
    end
endmodule

// File: rtl/din_deglitch.sv
module din_deglitch
    import dgl_pkg::*;
#(
    parameter int NCH      = 24,
    parameter int IVL_W    = 20,
    parameter int TICK_DIV = 10,
    parameter int ADDR_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    din,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic [NCH-1:0]    filt_out
);
    localparam int NB = (NCH + DGL_BYTE_W - 1) / DGL_BYTE_W;
    localparam int RW = NB * DGL_BYTE_W;

    logic             tick;
    logic [NCH-1:0]   sync_q;
    logic [NCH-1:0]   en_mask;
    logic [IVL_W-1:0] ivl_active;
    logic [IVL_W-1:0] ivl_staged;
    logic             clr_filt;
    logic [RW-1:0]    filt_pad;

    dgl_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    dgl_sync #(.W(NCH)) u_sync (
        .clk(clk),
        .d  (din),
        .q  (sync_q)
    );

    dgl_regs #(.NCH(NCH), .IVL_W(IVL_W), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .en_mask   (en_mask),
        .ivl_active(ivl_active),
        .ivl_staged(ivl_staged),
        .clr_filt  (clr_filt)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        dgl_chan #(.IVL_W(IVL_W)) u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick   (tick),
            .clr    (clr_filt),
            .en     (en_mask[c]),
            .sync_in(sync_q[c]),
            .ivl    (ivl_active),
            .filt_o (filt_out[c])
        );
    end

    assign filt_pad = RW'(filt_out);

    always_comb begin
        rd_data = '0;
        for (int b = 0; b < NB; b++) begin
            if (rd_addr == ADDR_W'(DGL_RD_BASE + b))
                rd_data = filt_pad[b*DGL_BYTE_W +: DGL_BYTE_W];
        end
    end
endmodule

// File: rtl/dgl_checker.sv
module dgl_checker
    import dgl_pkg::*;
#(
    parameter int NCH      = 24,
    parameter int IVL_W    = 20,
    parameter int TICK_DIV = 10,
    parameter int ADDR_W   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic [NCH-1:0]    en_mask,
    input logic [IVL_W-1:0]  ivl_active,
    input logic [IVL_W-1:0]  ivl_staged,
    input logic              clr_filt,
    input logic [NCH-1:0]    sync_q,
    input logic [NCH-1:0]    filt_out,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [7:0]        wr_data
);
    localparam int NB = (NCH + DGL_BYTE_W - 1) / DGL_BYTE_W;

    if (TICK_DIV > 1) begin : g_tick_chk
        assert_tick_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
            tick |=> !tick);
    end

    // R4: an enabled channel only ever moves to the level its input held one edge earlier
    assert_flip_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((filt_out ^ $past(filt_out)) & en_mask & $past(en_mask)
         & (filt_out ^ $past(sync_q))) == '0);

    // R5: with a non-zero interval, a level just arrived cannot be accepted at the next edge
    assert_no_early_flip_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ivl_active) != '0 && !$past(clr_filt)) |->
        (((filt_out ^ $past(filt_out)) & en_mask & $past(en_mask)
          & ($past(sync_q) ^ $past(sync_q, 2))) == '0));

    assert_commit_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ivl_active != $past(ivl_active)) |->
        ($past(wr_en) && $past(wr_addr) == ADDR_W'(DGL_CMD_ADDR)
         && $past(wr_data[DGL_CMD_COMMIT]) && ivl_active == $past(ivl_staged)));

    assert_enable_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (en_mask != $past(en_mask)) |->
        ($past(wr_en) && $past(wr_addr) >= ADDR_W'(DGL_EN_BASE)
         && $past(wr_addr) < ADDR_W'(DGL_EN_BASE + NB)));
endmodule

bind din_deglitch dgl_checker #(
    .NCH(NCH), .IVL_W(IVL_W), .TICK_DIV(TICK_DIV), .ADDR_W(ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .en_mask   (en_mask),
    .ivl_active(ivl_active),
    .ivl_staged(ivl_staged),
    .clr_filt  (clr_filt),
    .sync_q    (sync_q),
    .filt_out  (filt_out),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data)
);

// File: tb/sim_din_deglitch.sv
module sim_din_deglitch;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int NCH   = 24;
    localparam int IVL_W = 20;
    localparam int DIV   = 10;
    localparam int AW    = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NCH-1:0] din = '0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [7:0]    rd_data;
    logic [NCH-1:0] filt_out;

    always #2 clk = ~clk;

    din_deglitch #(.NCH(NCH), .IVL_W(IVL_W), .TICK_DIV(DIV), .ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .din(din), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .filt_out(filt_out)
    );

    // behavioural reference
    bit [NCH-1:0] m_s1, m_s2, m_held, m_en;
    bit [23:0]    m_stg;
    int           m_cnt [NCH];
    int           m_ivl, m_tc;
    int           checks = 0, errors = 0, cyc = 0;
    string        phase = "R1";

    always @(posedge clk) begin : model
        bit tk, clr, com;
        int a;
        cyc++;
        a   = int'(wr_addr);
        tk  = (m_tc == DIV - 1);
        clr = wr_en && a == 12 && wr_data[1];
        com = wr_en && a == 12 && wr_data[0];
        for (int c = 0; c < NCH; c++) begin
            if (!rst_n || clr || !m_en[c]) begin
                m_held[c] = m_s2[c];
                m_cnt[c]  = 0;
            end else if (m_s2[c] == m_held[c]) begin
                m_cnt[c] = 0;
            end else if (m_cnt[c] >= m_ivl) begin
                m_held[c] = m_s2[c];
                m_cnt[c]  = 0;
            end else if (tk) begin
                m_cnt[c] = m_cnt[c] + 1;
            end
        end
        if (!rst_n) begin
            m_en = '0; m_ivl = 0; m_stg = '0; m_tc = 0;
        end else begin
            m_tc = tk ? 0 : m_tc + 1;
            if (com) m_ivl = int'(m_stg[19:0]);
            if (wr_en && a >= 4 && a <= 6) m_stg[(a-4)*8 +: 8] = wr_data;
            if (wr_en && a >= 8 && a <= 10) m_en[(a-8)*8 +: 8] = wr_data;
        end
        m_s2 = m_s1;
        m_s1 = din;
    end

    always @(posedge clk) begin
        #1;
        rd_addr = rd_addr + 1'b1;
    end

    always @(negedge clk) begin
        if (cyc >= 3) begin
            bit [NCH-1:0] exp_f;
            bit [7:0]     exp_r;
            for (int c = 0; c < NCH; c++) exp_f[c] = m_en[c] ? m_held[c] : m_s2[c];
            exp_r = (rd_addr < 3) ? exp_f[int'(rd_addr)*8 +: 8] : 8'h00;
            checks++;
            if (filt_out !== exp_f) begin
                errors++;
                $display("FAIL %s filt_out cyc=%0d actual=%h expected=%h", phase, cyc, filt_out, exp_f);
            end
            checks++;
            if (rd_data !== exp_r) begin
                errors++;
                $display("FAIL R9 rd_data addr=%0d cyc=%0d actual=%h expected=%h", rd_addr, cyc, rd_data, exp_r);
            end
        end
    end

    always @(posedge clk) begin
        if (cyc > 100000) begin
            errors++;
            $display("FAIL watchdog in %s actual=running expected=finished", phase);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic step(int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic drive(bit [NCH-1:0] v);
        @(posedge clk);
        #1 din = v;
    endtask

    task automatic wr(int a, int d);
        @(posedge clk);
        #1;
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = 8'(d);
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    initial begin
        bit [NCH-1:0] v;
        din = 24'hA5C33C;
        step(6);
        #1 rst_n = 1'b1;
        phase = "R1";  step(6);
        phase = "R2";  repeat (30) drive(NCH'($urandom));
        phase = "R8";  wr(8, 'hFF); wr(9, 'h0F); wr(10, 'h00); step(4);
        phase = "R10"; repeat (30) drive(NCH'($urandom));
        phase = "R6";  wr(4, 3); wr(5, 0); wr(6, 'hF0);
        repeat (20) drive(NCH'($urandom));
        wr(12, 1);
        phase = "R4";  v = 24'h0F0F0F; drive(v); step(50); v = ~v; drive(v); step(50);
        phase = "R5";
        repeat (6) begin
            drive(v ^ 24'h00FF3C); step(12);
            drive(v); step(8);
        end
        drive(v ^ 24'h000FF0); step(45);
        phase = "R7";  v = NCH'($urandom); drive(v); step(5); wr(12, 2); step(10);
        phase = "R3";  wr(4, 1); wr(12, 1); wr(9, 'hFF); wr(10, 'hFF);
        repeat (40) begin drive(NCH'($urandom)); step($urandom_range(2, 25)); end
        phase = "R9";  wr(0, 'hFF); wr(2, 'h55); wr(13, 'hFF);
        repeat (30) begin drive(NCH'($urandom)); step($urandom_range(1, 12)); end
        step(5);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule